// File: doc/BRIEF.md
# SCL Low-Time Watchdog

This block guards the clock line of a two-wire serial responder. It takes an already synchronized copy of SCL, a flag that is high while the responder itself holds the clock low, and single-cycle strobes that mark the START and STOP of a transaction. From these it measures how long the clock stays low. When a timing rule is broken, it emits a one-cycle pulse that the surrounding interface logic uses to return to idle.

The rules come from an 8-bit mode code. The 100 kHz timed mode checks three limits:
- one continuous low-time limit;
- a cumulative limit on clock-low time while the responder stretches;
- a cumulative limit on clock-low time spent with the controller holding the clock.

The 400 kHz timed mode checks only a shorter continuous limit. A two-second stuck-low limit applies in every mode, and it is the only rule in the untimed mode and in any unrecognized code.

All time is counted in milliseconds from a prescaled tick. After a pulse, all counters are cleared and the block stays silent until SCL has been seen high again.

Top module: `scl_timeout_guard`

## Requirements
- R1: A tick fires once every `TICK_DIV` clock cycles. The counters change only on ticks. The pulse appears one cycle after the tick that takes a counter past its limit.
- R2: With mode code 0x1E, the pulse fires when SCL has been continuously low for more than `SLOW_LOW_MS` (30) ticks.
- R3: With mode code 0x1E, the pulse fires when low time with the stretch flag high, summed over one transaction, exceeds `RESP_CUM_MS` (25) ticks.
- R4: With mode code 0x1E, the pulse fires when low time with the stretch flag low, summed over one transaction, exceeds `CTRL_CUM_MS` (10) ticks.
- R5: With mode code 0x09, the pulse fires when SCL has been continuously low for more than `FAST_LOW_MS` (15) ticks. The cumulative limits are not applied in this mode.
- R6: With mode code 0x08, or any code other than 0x1E and 0x09, only the stuck-low limit of `LONG_MS` (2000) ticks applies.
- R7: The stuck-low limit (continuous low for more than `LONG_MS` ticks) is checked in every mode.
- R8: Either strobe (START or STOP) clears both cumulative counters. Any cycle with SCL high clears the continuous counter.
- R9: The pulse lasts exactly one cycle. All counters read zero in the cycle after it.
- R10: After a pulse, no further pulse occurs while SCL stays low. Once SCL has been high for one cycle, counting restarts from zero.
- R11: During and right after reset, the pulse output is low.
- R12: Traffic whose low segments stay within every limit that applies never produces a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized SCL level |
| stretch_i | input | 1 | High while the responder holds SCL low |
| start_i | input | 1 | One-cycle START strobe |
| stop_i | input | 1 | One-cycle STOP strobe |
| mode_i | input | 8 | Mode code (0x1E, 0x09, 0x08; others behave as 0x08) |
| comm_reset_o | output | 1 | One-cycle interface reset pulse |

## Verification
The assertions assume the following about the inputs:
- `scl_i` is already free of metastability;
- the strobes last one cycle;
- the mode code is read afresh each cycle. Each property therefore compares a pulse against the mode and counter values of the previous cycle, not against a mode that is held steady.

The stimulus respects these assumptions in the following ways:
- It changes the mode only while SCL is high.
- It sends strobes only as isolated single cycles.
- In the random traffic, it bounds each segment's possible tick count with `ceil(len/TICK_DIV)`, so every cumulative sum stays provably below its limit.

// File: rtl/sclg_pkg.sv
package sclg_pkg;

    localparam logic [7:0] MODE_SLOW_TIMED = 8'h1E;
    localparam logic [7:0] MODE_FAST_TIMED = 8'h09;
    localparam logic [7:0] MODE_FAST_PLAIN = 8'h08;

    typedef enum logic [1:0] {
        RULE_NONE = 2'd0,
        RULE_SLOW = 2'd1,
        RULE_FAST = 2'd2
    } rule_e;

    function automatic rule_e decode_mode(input logic [7:0] code);
        rule_e r;
        case (code)
            MODE_SLOW_TIMED: r = RULE_SLOW;
            MODE_FAST_TIMED: r = RULE_FAST;
            default:         r = RULE_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sclg_tick.sv
module sclg_tick #(
    parameter int unsigned DIV = 50000
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);

    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == CW'(DIV - 1)) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    generate
        if (DIV > 1) begin : g_gap_chk
            AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
                st_q.tick |=> !st_q.tick); // R1
        end
    endgenerate

endmodule

// File: rtl/sclg_accum.sv
module sclg_accum #(
    parameter int unsigned W = 11
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } acc_st_t;

    acc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (inc_i && (st_q.cnt != {W{1'b1}})) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    AST_ACC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> (st_q.cnt == $past(st_q.cnt)) || (st_q.cnt == $past(st_q.cnt) + 1'b1)); // R1

endmodule

// File: rtl/scl_timeout_guard.sv
module scl_timeout_guard
    import sclg_pkg::*;
#(
    parameter int unsigned TICK_DIV    = 50000,
    parameter int unsigned LONG_MS     = 2000,
    parameter int unsigned SLOW_LOW_MS = 30,
    parameter int unsigned FAST_LOW_MS = 15,
    parameter int unsigned RESP_CUM_MS = 25,
    parameter int unsigned CTRL_CUM_MS = 10
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       scl_i,
    input  logic       stretch_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic [7:0] mode_i,
    output logic       comm_reset_o
);

    localparam int unsigned CW       = $clog2(LONG_MS + 2);
    localparam int unsigned N_CUM    = 2;
    localparam int unsigned RESP_IDX = 0;
    localparam int unsigned CTRL_IDX = 1;

    typedef struct packed {
        logic pulse;
        logic armed;
    } guard_st_t;

    guard_st_t st_d, st_q;

    logic          tick;
    logic          clr_all;
    logic          cont_clr;
    logic          cont_inc;
    logic          cum_clr;
    logic [CW-1:0] cont_cnt;
    logic [CW-1:0] cum_cnt [N_CUM];
    rule_e         rule;
    logic          viol_long;
    logic          viol_slow;
    logic          viol_fast;
    logic          fire;

    sclg_tick #(.DIV(TICK_DIV)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    assign clr_all  = st_q.pulse | ~st_q.armed;
    assign cont_clr = clr_all | scl_i;
    assign cont_inc = tick & ~scl_i;
    assign cum_clr  = clr_all | start_i | stop_i;

    sclg_accum #(.W(CW)) u_cont (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (cont_clr),
        .inc_i  (cont_inc),
        .cnt_o  (cont_cnt)
    );

    generate
        for (genvar g = 0; g < N_CUM; g++) begin : g_cum
            logic cum_inc;
            assign cum_inc = tick & ~scl_i & (stretch_i == (g == RESP_IDX));
            sclg_accum #(.W(CW)) u_cum (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .clr_i  (cum_clr),
                .inc_i  (cum_inc),
                .cnt_o  (cum_cnt[g])
            );
        end
    endgenerate

    always_comb begin
        rule      = decode_mode(mode_i);
        viol_long = cont_cnt > CW'(LONG_MS);
        viol_slow = (rule == RULE_SLOW) &&
                    ((cont_cnt > CW'(SLOW_LOW_MS)) ||
                     (cum_cnt[RESP_IDX] > CW'(RESP_CUM_MS)) ||
                     (cum_cnt[CTRL_IDX] > CW'(CTRL_CUM_MS)));
        viol_fast = (rule == RULE_FAST) && (cont_cnt > CW'(FAST_LOW_MS));
        fire      = st_q.armed & ~st_q.pulse & (viol_long | viol_slow | viol_fast);

        st_d       = st_q;
        st_d.pulse = fire;
        if (scl_i)     st_d.armed = 1'b1;
        else if (fire) st_d.armed = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.pulse <= 1'b0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign comm_reset_o = st_q.pulse;

    AST_ONE_CYCLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.pulse |=> !st_q.pulse); // R9

    AST_CLEAR_AFTER_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.pulse |=> (cont_cnt == '0) && (cum_cnt[RESP_IDX] == '0) && (cum_cnt[CTRL_IDX] == '0)); // R9

    AST_PLAIN_LONG_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.pulse && $past(rule == RULE_NONE)) |-> ($past(cont_cnt) > CW'(LONG_MS))); // R6

    AST_FAST_CONT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.pulse && $past(rule == RULE_FAST)) |-> ($past(cont_cnt) > CW'(FAST_LOW_MS))); // R5

    AST_SLOW_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.pulse && $past(rule == RULE_SLOW)) |->
            (($past(cont_cnt) > CW'(SLOW_LOW_MS)) ||
             ($past(cum_cnt[RESP_IDX]) > CW'(RESP_CUM_MS)) ||
             ($past(cum_cnt[CTRL_IDX]) > CW'(CTRL_CUM_MS)))); // R2

endmodule

// File: tb/test_scl_timeout_guard.sv
module test_scl_timeout_guard;

    localparam int DIV      = 4;
    localparam int LONG     = 2000;
    localparam int SLOW_LOW = 30;
    localparam int FAST_LOW = 15;
    localparam int RESP_CUM = 25;
    localparam int CTRL_CUM = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       stretch = 1'b0;
    logic       start = 1'b0;
    logic       stop = 1'b0;
    logic [7:0] mode = 8'h08;
    logic       comm_reset;

    int checks = 0;
    int fails = 0;
    int first_k, npulse, dbl;
    bit prev;
    bit done = 1'b0;

    always #10 clk = ~clk;

    scl_timeout_guard #(
        .TICK_DIV    (DIV),
        .LONG_MS     (LONG),
        .SLOW_LOW_MS (SLOW_LOW),
        .FAST_LOW_MS (FAST_LOW),
        .RESP_CUM_MS (RESP_CUM),
        .CTRL_CUM_MS (CTRL_CUM)
    ) i_scl_timeout_guard (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .scl_i        (scl),
        .stretch_i    (stretch),
        .start_i      (start),
        .stop_i       (stop),
        .mode_i       (mode),
        .comm_reset_o (comm_reset)
    );

    // Cycle index at which the pulse shows when N more ticks are needed after SCL falls
    function automatic int win_lo(int n); return (n - 1) * DIV + 2; endfunction
    function automatic int win_hi(int n); return n * DIV + 1; endfunction
    function automatic int max_ticks(int len); return (len + DIV - 1) / DIV; endfunction
    function automatic bit expect_fire(logic [7:0] m, int ctrl_b, int resp_b, int seg_b);
        if (m == 8'h1E) return (ctrl_b > CTRL_CUM) || (resp_b > RESP_CUM) || (seg_b > SLOW_LOW);
        if (m == 8'h09) return seg_b > FAST_LOW;
        return seg_b > LONG;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_win(string req, int k, int n);
        checks++;
        if (k < win_lo(n) || k > win_hi(n)) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, k, win_lo(n), win_hi(n));
        end
    endtask

    task automatic clear_meas();
        first_k = 0; npulse = 0; dbl = 0; prev = 1'b0;
    endtask

    task automatic drive(int n, bit s, bit str, int strobe_every);
        for (int k = 1; k <= n; k++) begin
            scl = s;
            stretch = str;
            if (strobe_every > 0) start = (k % strobe_every == 0);
            @(posedge clk);
            #5;
            if (comm_reset) begin
                npulse++;
                if (first_k == 0) first_k = k;
                if (prev) dbl++;
            end
            prev = comm_reset;
            @(negedge clk);
        end
        if (strobe_every > 0) start = 1'b0;
    endtask

    task automatic strobe(bit is_start);
        if (is_start) start = 1'b1; else stop = 1'b1;
        drive(1, 1'b1, 1'b0, 0);
        start = 1'b0;
        stop = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R11: reset state
        repeat (5) @(negedge clk);
        check(comm_reset == 1'b0, "R11 pulse during reset", comm_reset, 0);
        rst_n = 1'b1;
        clear_meas();
        drive(8, 1'b1, 1'b0, 0);
        check(npulse == 0, "R11 pulse after reset", npulse, 0);

        // R5 / R1: fast timed mode, continuous low past 15 ticks
        mode = 8'h09;
        clear_meas();
        drive(200, 1'b0, 1'b0, 0);
        check_win("R5 fast continuous (R1 timing)", first_k, FAST_LOW + 1);
        check(npulse == 1, "R10 no refire while low", npulse, 1);
        check(dbl == 0, "R9 single cycle pulse", dbl, 0);

        // R10: one high cycle rearms, counting restarts from zero
        drive(1, 1'b1, 1'b0, 0);
        clear_meas();
        drive(80, 1'b0, 1'b0, 0);
        check_win("R10 rearm after high", first_k, FAST_LOW + 1);

        // R2: slow mode, continuous low with START strobes clearing cumulative counts
        mode = 8'h1E;
        drive(8, 1'b1, 1'b0, 0);
        clear_meas();
        drive(140, 1'b0, 1'b0, 16);
        check_win("R2 slow continuous", first_k, SLOW_LOW + 1);

        // R3: responder stretch accumulated over segments of 8 ticks
        drive(8, 1'b1, 1'b0, 0);
        strobe(1'b0);
        clear_meas();
        for (int s = 0; s < 3; s++) begin
            drive(32, 1'b0, 1'b1, 0);
            drive(4, 1'b1, 1'b0, 0);
        end
        check(npulse == 0, "R3 below responder limit", npulse, 0);
        clear_meas();
        drive(40, 1'b0, 1'b1, 0);
        check_win("R3 responder cumulative", first_k, RESP_CUM + 1 - 24);

        // R4: controller low accumulated over segments of 4 ticks
        drive(8, 1'b1, 1'b0, 0);
        strobe(1'b1);
        clear_meas();
        for (int s = 0; s < 2; s++) begin
            drive(16, 1'b0, 1'b0, 0);
            drive(4, 1'b1, 1'b0, 0);
        end
        check(npulse == 0, "R4 below controller limit", npulse, 0);
        clear_meas();
        drive(30, 1'b0, 1'b0, 0);
        check_win("R4 controller cumulative", first_k, CTRL_CUM + 1 - 8);

        // R8: STOP clears cumulative counts; SCL high clears continuous count
        drive(8, 1'b1, 1'b0, 0);
        strobe(1'b1);
        clear_meas();
        for (int s = 0; s < 2; s++) begin
            drive(16, 1'b0, 1'b0, 0);
            drive(4, 1'b1, 1'b0, 0);
        end
        strobe(1'b0);
        for (int s = 0; s < 2; s++) begin
            drive(16, 1'b0, 1'b0, 0);
            drive(4, 1'b1, 1'b0, 0);
        end
        check(npulse == 0, "R8 strobe clears cumulative", npulse, 0);
        mode = 8'h09;
        clear_meas();
        drive(56, 1'b0, 1'b0, 0);
        drive(1, 1'b1, 1'b0, 0);
        drive(56, 1'b0, 1'b0, 0);
        drive(4, 1'b1, 1'b0, 0);
        check(npulse == 0, "R8 high clears continuous", npulse, 0);

        // R7: untimed mode keeps only the stuck-low limit
        mode = 8'h08;
        clear_meas();
        drive(8100, 1'b0, 1'b0, 0);
        check_win("R7 stuck-low in untimed mode", first_k, LONG + 1);
        check(npulse == 1, "R7 single stuck-low pulse", npulse, 1);

        // R6: unrecognized code behaves as untimed mode
        drive(4, 1'b1, 1'b0, 0);
        mode = 8'h55;
        clear_meas();
        drive(8100, 1'b0, 1'b1, 0);
        check_win("R6 unknown code long only", first_k, LONG + 1);
        drive(4, 1'b1, 1'b0, 0);

        // R12: random traffic kept within every applicable limit
        for (int t = 0; t < 24; t++) begin
            int ctrl_b, resp_b, seg_b;
            logic [7:0] m;
            case ($urandom % 3)
                0:       m = 8'h1E;
                1:       m = 8'h09;
                default: m = 8'h08;
            endcase
            mode = m;
            drive(4, 1'b1, 1'b0, 0);
            strobe(1'b1);
            ctrl_b = 0; resp_b = 0; seg_b = 0;
            clear_meas();
            for (int s = 0; s < 8; s++) begin
                int len, mt;
                bit str;
                len = 1 + int'($urandom % 12);
                str = 1'($urandom % 2);
                mt = max_ticks(len);
                if (str ? (resp_b + mt > RESP_CUM) : (ctrl_b + mt > CTRL_CUM)) break;
                if (str) resp_b += mt; else ctrl_b += mt;
                if (mt > seg_b) seg_b = mt;
                drive(len, 1'b0, str, 0);
                drive(1 + int'($urandom % 8), 1'b1, 1'b0, 0);
            end
            strobe(1'b0);
            check(npulse == int'(expect_fire(m, ctrl_b, resp_b, seg_b)), "R12 random traffic", npulse, 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule